// File: doc/BRIEF.md
# Split-Merge Stream Control Unit

This unit is the control-flow stage of a multithreaded processor in which every instruction works directly on memory. It takes one stream descriptor at a time, together with the instruction that descriptor points at. A descriptor carries a program counter, an address prefix, a process tag and status bits. For the stream-management instructions the unit works out which descriptors come next, and it passes them one at a time to a downstream descriptor sink. Depending on the instruction there are zero, one or two of them. A fork instruction turns one stream into two. A join instruction performs an atomic toggle on a synchronization word: the first stream to arrive is dropped, and the second one carries on. A wait instruction spins by handing back its own descriptor unchanged until the word becomes nonzero. Two further instructions copy the prefix out to memory and load it back in. Every other opcode simply advances the program counter.

All memory operands use short addresses, which are formed by placing the descriptor's prefix above the instruction's offset. The unit owns a single-port memory port with one cycle of read latency. While a read-modify-write is in flight, or while a successor is still waiting for the sink, the unit drops its input ready.

Top module: `stream_ctl`

## Requirements
- R1: While reset is held, and in the first cycle after release, `out_valid` and `mem_req` are low. At most three cycles after `rst_n` rises, `in_ready` is high.
- R2: Opcodes are 3 bits wide: 1 fork, 2 join, 3 wait, 4 prefix-store, 5 prefix-load. Any other value is plain and yields one successor at pc+1 (wrapping modulo 2^PC_W), with prefix, process tag and status unchanged.
- R3: A fork yields two successors. The first is at the target and the second at pc+1, and both copy the prefix, process tag and status of the incoming descriptor.
- R4: A join whose operand reads zero writes 1 to the operand and yields no successor.
- R5: A join whose operand reads nonzero writes 0 to the operand and yields one successor at pc+1 with its prefix unchanged.
- R6: For a join and for a wait that writes, the write comes in the cycle directly after the read, at the same address, and no other memory access falls between them.
- R7: A wait whose operand reads nonzero writes 0 and yields one successor at pc+1.
- R8: A wait whose operand reads zero performs no write and yields one successor at the same pc.
- R9: Every memory access uses the address {prefix, offset}, with the prefix in the upper PFX_W bits.
- R10: A prefix-store writes the prefix, zero-extended to DW bits, to its operand and yields one successor at pc+1.
- R11: A prefix-load reads its operand and yields one successor at pc+1, whose prefix is the low PFX_W bits of the word it read.
- R12: In the cycle after a descriptor is accepted, `in_ready` is low. It stays low until the last successor has been taken, or until the join that drops the stream has written its operand.
- R13: While `out_valid` is high and `out_ready` is low, the descriptor on the output holds steady in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Incoming descriptor is valid |
| in_ready | output | 1 | Unit can accept a descriptor |
| in_op | input | 3 | Instruction opcode |
| in_pc | input | PC_W | Program counter of the stream |
| in_tgt | input | PC_W | Fork target |
| in_ofs | input | OFS_W | Short-address offset of the operand |
| in_pfx | input | PFX_W | Prefix of the stream |
| in_pid | input | PID_W | Process tag |
| in_stat | input | ST_W | Status bits |
| out_valid | output | 1 | Successor descriptor is valid |
| out_ready | input | 1 | Sink takes the successor |
| out_pc | output | PC_W | Successor program counter |
| out_pfx | output | PFX_W | Successor prefix |
| out_pid | output | PID_W | Successor process tag |
| out_stat | output | ST_W | Successor status |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | PFX_W+OFS_W | Short address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read request |

## Verification
The bench builds the unit with an 8-bit program counter, 4-bit prefix and offset fields, and 8-bit data. With those widths the whole 256-word short-address space fits in a bench memory that can be compared word by word at the end. They also bring the program-counter wrap from 255 to 0, and a prefix-load whose word has bits above the prefix field set, within reach. The sink stalls one cycle in every three, so forks and single successors both meet back-pressure. One scenario runs a complete fork and join on a shared synchronization word.

// File: rtl/scu_pkg.sv
package scu_pkg;

  typedef enum logic [2:0] {
    OP_PLAIN = 3'd0,
    OP_FORK  = 3'd1,
    OP_JOIN  = 3'd2,
    OP_WAIT  = 3'd3,
    OP_PSTO  = 3'd4,
    OP_PLOD  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_MOD  = 3'd2,
    ST_WR   = 3'd3,
    ST_OUT1 = 3'd4,
    ST_OUT2 = 3'd5
  } st_e;

  // operations that read their operand before deciding anything
  function automatic logic op_reads(op_e op);
    return (op == OP_JOIN) || (op == OP_WAIT) || (op == OP_PLOD);
  endfunction

endpackage

// File: rtl/scu_addr.sv
module scu_addr #(
  parameter int PFX_W = 6,
  parameter int OFS_W = 4,
  localparam int AW = PFX_W + OFS_W
) (
  input  logic [PFX_W-1:0] pfx,
  input  logic [OFS_W-1:0] ofs,
  output logic [AW-1:0]    addr
);
  // prefix selects the window, the instruction picks the word inside it
  assign addr = {pfx, ofs};
endmodule

// File: rtl/scu_succ.sv
module scu_succ
  import scu_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int PFX_W = 6,
  parameter int DW    = 16
) (
  input  op_e              op,
  input  logic             second,
  input  logic [PC_W-1:0]  pc,
  input  logic [PC_W-1:0]  tgt,
  input  logic [PFX_W-1:0] pfx,
  input  logic [DW-1:0]    word,
  output logic [PC_W-1:0]  nx_pc,
  output logic [PFX_W-1:0] nx_pfx
);
  logic [PC_W-1:0] pc_inc;
  logic            word_zero;

  assign pc_inc    = pc + PC_W'(1);
  assign word_zero = (word == '0);

  always_comb begin
    nx_pc  = pc_inc;
    nx_pfx = pfx;
    unique case (op)
      OP_FORK: nx_pc  = second ? pc_inc : tgt;
      OP_WAIT: nx_pc  = word_zero ? pc : pc_inc;
      OP_PLOD: nx_pfx = word[PFX_W-1:0];
      default: ;
    endcase
  end
endmodule

// File: rtl/scu_fsm.sv
module scu_fsm
  import scu_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic accept,
  input  op_e  new_op,
  input  op_e  cur_op,
  input  logic rd_zero,
  input  logic out_ready,
  output st_e  state
);
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (op_reads(new_op))      st_d = ST_RD;
          else if (new_op == OP_PSTO) st_d = ST_WR;
          else                        st_d = ST_OUT1;
        end
      end
      ST_RD:   st_d = ST_MOD;
      ST_MOD:  st_d = (cur_op == OP_JOIN && rd_zero) ? ST_IDLE : ST_OUT1;
      ST_WR:   st_d = ST_OUT1;
      ST_OUT1: if (out_ready) st_d = (cur_op == OP_FORK) ? ST_OUT2 : ST_IDLE;
      ST_OUT2: if (out_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/stream_ctl.sv
module stream_ctl
  import scu_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int PFX_W = 6,
  parameter int OFS_W = 4,
  parameter int DW    = 16,
  parameter int PID_W = 4,
  parameter int ST_W  = 4,
  localparam int AW = PFX_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [PC_W-1:0]  in_pc,
  input  logic [PC_W-1:0]  in_tgt,
  input  logic [OFS_W-1:0] in_ofs,
  input  logic [PFX_W-1:0] in_pfx,
  input  logic [PID_W-1:0] in_pid,
  input  logic [ST_W-1:0]  in_stat,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PC_W-1:0]  out_pc,
  output logic [PFX_W-1:0] out_pfx,
  output logic [PID_W-1:0] out_pid,
  output logic [ST_W-1:0]  out_stat,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata
);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // captured descriptor and instruction
  st_e              state;
  op_e              d_op;
  logic [PC_W-1:0]  d_pc, d_tgt;
  logic [OFS_W-1:0] d_ofs;
  logic [PFX_W-1:0] d_pfx;
  logic [PID_W-1:0] d_pid;
  logic [ST_W-1:0]  d_st;
  logic [DW-1:0]    rd_q;
  logic             accept, cap_en, word_en, rd_zero, mod_we;
  logic [DW-1:0]    pfx_ext;

  assign in_ready = (state == ST_IDLE) && rst_i;
  assign accept   = in_valid && in_ready;
  assign cap_en   = accept;
  assign word_en  = (state == ST_MOD);
  assign rd_zero  = (mem_rdata == '0);

  always_ff @(posedge clk) begin
    if (cap_en) begin
      d_op  <= op_e'(in_op);
      d_pc  <= in_pc;
      d_tgt <= in_tgt;
      d_ofs <= in_ofs;
      d_pfx <= in_pfx;
      d_pid <= in_pid;
      d_st  <= in_stat;
    end
  end

  always_ff @(posedge clk) begin
    if (word_en) rd_q <= mem_rdata;
  end

  scu_fsm i_fsm (
    .clk       (clk),
    .rst_ni    (rst_i),
    .accept    (accept),
    .new_op    (op_e'(in_op)),
    .cur_op    (d_op),
    .rd_zero   (rd_zero),
    .out_ready (out_ready),
    .state     (state)
  );

  scu_addr #(.PFX_W(PFX_W), .OFS_W(OFS_W)) i_addr (
    .pfx  (d_pfx),
    .ofs  (d_ofs),
    .addr (mem_addr)
  );

  // prefix widened or cut to the data word
  generate
    if (DW > PFX_W) begin : g_pfx_pad
      assign pfx_ext = {{(DW-PFX_W){1'b0}}, d_pfx};
    end else begin : g_pfx_cut
      assign pfx_ext = d_pfx[DW-1:0];
    end
  endgenerate

  // second half of the atomic update: join always writes, wait only on nonzero
  assign mod_we = (d_op == OP_JOIN) || (d_op == OP_WAIT && !rd_zero);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    unique case (state)
      ST_RD: mem_req = 1'b1;
      ST_MOD: begin
        mem_req = mod_we;
        mem_we  = mod_we;
        if (d_op == OP_JOIN) mem_wdata = {{(DW-1){1'b0}}, rd_zero};
      end
      ST_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = pfx_ext;
      end
      default: ;
    endcase
  end

  scu_succ #(.PC_W(PC_W), .PFX_W(PFX_W), .DW(DW)) i_succ (
    .op     (d_op),
    .second (state == ST_OUT2),
    .pc     (d_pc),
    .tgt    (d_tgt),
    .pfx    (d_pfx),
    .word   (rd_q),
    .nx_pc  (out_pc),
    .nx_pfx (out_pfx)
  );

  assign out_valid = (state == ST_OUT1) || (state == ST_OUT2);
  assign out_pid   = d_pid;
  assign out_stat  = d_st;

endmodule

// File: rtl/stream_ctl_chk.sv
module stream_ctl_chk
  import scu_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int PFX_W = 6,
  parameter int OFS_W = 4,
  parameter int DW    = 16,
  parameter int PID_W = 4,
  parameter int ST_W  = 4,
  localparam int AW = PFX_W + OFS_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic [PID_W-1:0] in_pid,
  input logic [ST_W-1:0]  in_stat,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PC_W-1:0]  out_pc,
  input logic [PFX_W-1:0] out_pfx,
  input logic [PID_W-1:0] out_pid,
  input logic [ST_W-1:0]  out_stat,
  input logic             mem_req,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_wdata,
  input logic [DW-1:0]    mem_rdata
);
  op_e              cap_op;
  logic [PID_W-1:0] cap_pid;
  logic [ST_W-1:0]  cap_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_op  <= OP_PLAIN;
      cap_pid <= '0;
      cap_st  <= '0;
    end else if (in_valid && in_ready) begin
      cap_op  <= op_e'(in_op);
      cap_pid <= in_pid;
      cap_st  <= in_stat;
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready); // R12

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pc) && $stable(out_pfx)); // R13

  AST_RMW_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && (cap_op == OP_JOIN || cap_op == OP_WAIT)
    |-> $past(mem_req && !mem_we) && mem_addr == $past(mem_addr)); // R6

  AST_SUCC_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pid == cap_pid && out_stat == cap_st); // R3

  AST_WAIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && cap_op == OP_WAIT |-> mem_wdata == '0 && mem_rdata != '0); // R7

  AST_JOIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && cap_op == OP_JOIN
    |-> mem_wdata == {{(DW-1){1'b0}}, (mem_rdata == '0)}); // R4
endmodule

bind stream_ctl stream_ctl_chk #(
  .PC_W(PC_W), .PFX_W(PFX_W), .OFS_W(OFS_W), .DW(DW), .PID_W(PID_W), .ST_W(ST_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_pid(in_pid), .in_stat(in_stat),
  .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc),
  .out_pfx(out_pfx), .out_pid(out_pid), .out_stat(out_stat),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
);

// File: tb/test_stream_ctl.sv
`timescale 1ns/1ps
module test_stream_ctl;
  localparam int PC_W = 8, PFX_W = 4, OFS_W = 4, DW = 8, PID_W = 3, ST_W = 2;
  localparam int AW = PFX_W + OFS_W;
  localparam int DEW = PC_W + PFX_W + PID_W + ST_W;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, in_valid, in_ready, out_valid, out_ready, mem_req, mem_we;
  logic [2:0] in_op;
  logic [PC_W-1:0] in_pc, in_tgt, out_pc;
  logic [OFS_W-1:0] in_ofs;
  logic [PFX_W-1:0] in_pfx, out_pfx;
  logic [PID_W-1:0] in_pid, out_pid;
  logic [ST_W-1:0] in_stat, out_stat;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  stream_ctl #(.PC_W(PC_W), .PFX_W(PFX_W), .OFS_W(OFS_W), .DW(DW),
               .PID_W(PID_W), .ST_W(ST_W)) i_stream_ctl (.*);

  logic [DW-1:0] mem  [NW];
  logic [DW-1:0] rmem [NW];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  logic [DEW-1:0] expq[$];
  int errs = 0, checks = 0, cyc = 0, xfers = 0, rdy_cnt = 0;
  bit started = 0, no_write = 0, hold_pending = 0, prev_rd = 0;
  logic [AW-1:0] exp_addr, prev_addr;
  logic [DEW-1:0] held;
  string cur_tag = "R2";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the reference queue
  always @(negedge clk) begin
    bit rdy;
    logic [DEW-1:0] cur, e;
    cyc++;
    rdy_cnt++;
    rdy = (rdy_cnt % 3) != 0;
    if (cyc > 20000) begin
      errs++; checks++;
      $display("FAIL R12 watchdog: actual=busy expected=idle");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
    if (started) begin
      cur = {out_pc, out_pfx, out_pid, out_stat};
      if (out_valid) begin
        if (hold_pending) chk(cur == held, "R13", "held descriptor", 32'(cur), 32'(held));
        if (rdy) begin
          xfers++;
          if (expq.size() == 0) chk(1'b0, "R4", "successor not expected", 32'(out_pc), 0);
          else begin
            e = expq.pop_front();
            chk(cur == e, cur_tag, "successor", 32'(cur), 32'(e));
          end
        end
        hold_pending = !rdy;
        held = cur;
      end else hold_pending = 0;
      if (mem_req) begin
        chk(mem_addr == exp_addr, "R9", "address", 32'(mem_addr), 32'(exp_addr));
        if (mem_we && no_write) chk(1'b0, "R8", "write on zero wait", 1, 0);
        if (mem_we && prev_rd)
          chk(mem_addr == prev_addr, "R6", "write after read", 32'(mem_addr), 32'(prev_addr));
      end
      prev_rd = mem_req && !mem_we;
      prev_addr = mem_addr;
    end
    out_ready = rdy;
  end

  task automatic push(input logic [PC_W-1:0] pc, input logic [PFX_W-1:0] pf,
                      input logic [PID_W-1:0] pid, input logic [ST_W-1:0] st);
    expq.push_back({pc, pf, pid, st});
  endtask

  task automatic send(input logic [2:0] op, input logic [PC_W-1:0] pc,
                      input logic [PC_W-1:0] tgt, input logic [PFX_W-1:0] pf,
                      input logic [OFS_W-1:0] ofs, input logic [PID_W-1:0] pid,
                      input logic [ST_W-1:0] st, input string tag);
    logic [AW-1:0] a;
    logic [DW-1:0] v;
    logic [PC_W-1:0] npc;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    a = {pf, ofs};
    v = rmem[a];
    npc = pc + 1'b1;
    exp_addr = a;
    no_write = 0;
    cur_tag = tag;
    case (op)
      3'd1: begin push(tgt, pf, pid, st); push(npc, pf, pid, st); end
      3'd2: if (v == 0) rmem[a] = 1; else begin rmem[a] = 0; push(npc, pf, pid, st); end
      3'd3: if (v != 0) begin rmem[a] = 0; push(npc, pf, pid, st); end
            else begin no_write = 1; push(pc, pf, pid, st); end
      3'd4: begin rmem[a] = DW'(pf); push(npc, pf, pid, st); end
      3'd5: push(npc, v[PFX_W-1:0], pid, st);
      default: push(npc, pf, pid, st);
    endcase
    in_op = op; in_pc = pc; in_tgt = tgt; in_pfx = pf; in_ofs = ofs;
    in_pid = pid; in_stat = st; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R12", "ready after accept", 32'(in_ready), 0);
    while (!in_ready) @(negedge clk);
  endtask

  initial begin
    int x0;
    int bad;
    for (int i = 0; i < NW; i++) begin mem[i] = '0; rmem[i] = '0; end
    mem[8'h2C] = 8'hFD; rmem[8'h2C] = 8'hFD;
    mem[8'h71] = 8'h55; rmem[8'h71] = 8'h55;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_op = '0; in_pc = '0; in_tgt = '0; in_pfx = '0; in_ofs = '0; in_pid = '0; in_stat = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1", "out_valid in reset", 32'(out_valid), 0);
    chk(!mem_req, "R1", "mem_req in reset", 32'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !mem_req, "R1", "idle after release", 32'({out_valid, mem_req}), 0);
    repeat (2) @(negedge clk);
    chk(in_ready, "R1", "ready after release", 32'(in_ready), 1);
    started = 1;

    send(3'd0, 8'd5, 8'd0, 4'd3, 4'd1, 3'd2, 2'd1, "R2");
    send(3'd7, 8'd255, 8'd9, 4'd6, 4'd2, 3'd7, 2'd3, "R2");
    send(3'd1, 8'd10, 8'd40, 4'd2, 4'd0, 3'd5, 2'd1, "R3");
    send(3'd1, 8'd100, 8'd3, 4'd15, 4'd0, 3'd1, 2'd2, "R3");

    // fork then join on a shared word at {3,5}
    send(3'd1, 8'd20, 8'd30, 4'd3, 4'd0, 3'd4, 2'd0, "R3");
    x0 = xfers;
    send(3'd2, 8'd22, 8'd0, 4'd3, 4'd5, 3'd4, 2'd0, "R4");
    chk(mem[8'h35] == 8'd1, "R4", "join word after first arrival", 32'(mem[8'h35]), 1);
    send(3'd2, 8'd31, 8'd0, 4'd3, 4'd5, 3'd4, 2'd0, "R5");
    chk(xfers - x0 == 1, "R4", "survivors of join", 32'(xfers - x0), 1);
    chk(mem[8'h35] == 8'd0, "R5", "join word restored", 32'(mem[8'h35]), 0);
    send(3'd2, 8'd60, 8'd0, 4'd7, 4'd1, 3'd3, 2'd1, "R5");

    send(3'd3, 8'd70, 8'd0, 4'd1, 4'd2, 3'd6, 2'd2, "R8");
    send(3'd4, 8'd71, 8'd0, 4'd1, 4'd2, 3'd6, 2'd2, "R10");
    chk(mem[8'h12] == 8'd1, "R10", "stored prefix", 32'(mem[8'h12]), 1);
    send(3'd3, 8'd70, 8'd0, 4'd1, 4'd2, 3'd6, 2'd2, "R7");
    chk(mem[8'h12] == 8'd0, "R7", "wait cleared word", 32'(mem[8'h12]), 0);
    send(3'd5, 8'd80, 8'd0, 4'd2, 4'd12, 3'd2, 2'd0, "R11");
    send(3'd4, 8'd90, 8'd0, 4'd9, 4'd3, 3'd0, 2'd3, "R10");

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R2", "pending successors", 32'(expq.size()), 0);
    bad = 0;
    for (int i = 0; i < NW; i++) if (mem[i] !== rmem[i]) bad++;
    chk(bad == 0, "R9", "memory image mismatches", 32'(bad), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule